// File: doc/BRIEF.md
# Miss-Status Entry Address Matcher

This block keeps a small file of outstanding-miss entries for a cache and answers the question "is a miss to this line already pending?" Each entry records a cache-line address, a secure flag, an uncacheable flag, a valid bit and an in-service bit. The line address is stored with the offset bits already removed. A caller presents an address and a secure bit on the lookup port. In the same cycle it gets back a hit flag, the index of the matching entry, and that entry's in-service bit.

The matching rule is implemented once, inside the block, so no caller can apply it differently. A lookup hits only when the line addresses are equal and the secure bits are equal, and it never returns an entry that was opened for an uncacheable access. New entries are claimed through a valid/ready allocate port. The block always grants the lowest free slot, and it reports that index before the clock edge. Entries are marked in service and released through plain index-plus-strobe ports.

The allocate port follows valid/ready rules. `alloc_ready` is high whenever at least one slot is free. A request is accepted on a rising edge where `alloc_valid` and `alloc_ready` are both high. While the file is full, `alloc_ready` is low and a pending request changes nothing. The caller may hold its request until a slot is released.

Top module: `msm_matcher`

## Requirements
- R1: After a synchronous active-high reset, every entry is invalid. `full` is 0, `alloc_ready` is 1, `alloc_idx` is 0, and every lookup misses.
- R2: An entry stores only the line part of its address, meaning the address with its low log2(LINE_BYTES) bits dropped. A lookup to any byte in the same line matches, and a lookup to an address in the next line does not.
- R3: A lookup hits only when the secure bit is equal as well. The same line requested with the other secure value misses.
- R4: An entry allocated with the uncacheable flag set is never reported as a match, whatever the lookup address and secure bit.
- R5: A lookup is combinational. `lk_hit`, `lk_idx` and `lk_in_svc` follow `lk_addr` and `lk_secure` in the same cycle, with no clock edge needed. If two entries ever match, the lower index is returned.
- R6: `alloc_idx` always shows the lowest-numbered free entry. An accepted allocation writes that entry on the next rising edge, with its in-service bit cleared.
- R7: `full` is 1 exactly when every entry is valid, and `alloc_ready` is then 0. An allocation presented while full leaves all entries unchanged.
- R8: A pulse on `dealloc_valid` with `dealloc_idx` invalidates that entry at the next edge. Lookups to it then miss, and its slot becomes allocatable again.
- R9: A pulse on `svc_valid` with `svc_idx` sets that entry's in-service bit. A hit reports the bit on `lk_in_svc`, and a fresh allocation of the slot clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_secure | input | 1 | Lookup secure attribute |
| lk_hit | output | 1 | A cacheable valid entry matches the lookup |
| lk_idx | output | IDX_W | Index of the matching entry (lowest if several) |
| lk_in_svc | output | 1 | In-service bit of the matching entry, 0 on miss |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A free entry exists |
| alloc_addr | input | ADDR_W | Byte address of the new miss |
| alloc_secure | input | 1 | Secure attribute of the new miss |
| alloc_uncache | input | 1 | New miss is an uncacheable access |
| alloc_idx | output | IDX_W | Entry that an accepted request will occupy |
| dealloc_valid | input | 1 | Release strobe |
| dealloc_idx | input | IDX_W | Entry to release |
| svc_valid | input | 1 | Mark-in-service strobe |
| svc_idx | input | IDX_W | Entry to mark in service |
| full | output | 1 | All entries valid |

## Verification
The embedded checks assume that callers never open a second cacheable entry for a line and secure value that already have one. Under that assumption at most one entry can match a lookup. They also assume that release and in-service strobes name entries that are currently valid. The stimulus gives each allocation a distinct line, or a different secure value or uncacheable flag. It releases and marks only slots it has itself filled. The duplicate-match case is therefore never driven, and the one-hot check on the match vector stays quiet.

// File: rtl/msm_pkg.sv
package msm_pkg;

  // Per-entry state bits, kept together so an entry is one register group.
  typedef struct packed {
    logic vld;   // entry holds an outstanding miss
    logic sec;   // secure attribute of the miss
    logic unc;   // allocated for an uncacheable access
    logic svc;   // request has been issued downstream
  } ent_flags_t;

  localparam ent_flags_t ENT_EMPTY = '{vld: 1'b0, sec: 1'b0, unc: 1'b0, svc: 1'b0};

endpackage

// File: rtl/msm_entry.sv
module msm_entry
  import msm_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_sec,
  input  logic              wr_unc,
  input  logic              clr_en,
  input  logic              svc_en,
  output logic [LINE_W-1:0] line_q,
  output ent_flags_t        flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= ENT_EMPTY;
      line_q  <= '0;
    end else if (wr_en) begin
      flags_q <= '{vld: 1'b1, sec: wr_sec, unc: wr_unc, svc: 1'b0};
      line_q  <= wr_line;
    end else begin
      if (clr_en) flags_q.vld <= 1'b0;
      if (svc_en) flags_q.svc <= 1'b1;
    end
  end

  // R6: a written slot becomes valid with a clean in-service bit
  assert_alloc_fills_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flags_q.vld && !flags_q.svc));

  // R8: a release without a concurrent write frees the slot
  assert_release_frees_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !wr_en) |=> !flags_q.vld);

  // R9: marking in service sets the bit
  assert_svc_marks_R9: assert property (@(posedge clk) disable iff (rst)
    (svc_en && !wr_en) |=> flags_q.svc);

endmodule

// File: rtl/msm_cmp.sv
module msm_cmp
  import msm_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic [LINE_W-1:0] ent_line,
  input  ent_flags_t        ent_flags,
  input  logic [LINE_W-1:0] key_line,
  input  logic              key_sec,
  output logic              match
);

  // The single place where the match rule is defined: line, secure bit,
  // valid, and never an uncacheable entry.
  always_comb begin
    match = ent_flags.vld && !ent_flags.unc &&
            (ent_line == key_line) && (ent_flags.sec == key_sec);
  end

endmodule

// File: rtl/msm_lowest.sv
module msm_lowest #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Scan from the top so the lowest set bit is the last written.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        any = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/msm_matcher.sv
module msm_matcher
  import msm_pkg::*;
#(
  parameter int NUM_ENT    = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int IDX_W      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_secure,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              lk_in_svc,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              alloc_secure,
  input  logic              alloc_uncache,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              dealloc_valid,
  input  logic [IDX_W-1:0]  dealloc_idx,
  input  logic              svc_valid,
  input  logic [IDX_W-1:0]  svc_idx,
  output logic              full
);

  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS_W;

  // Alignment: keep only the line bits, the offset is masked away.
  logic [LINE_W-1:0] lk_line, alloc_line;
  assign lk_line    = lk_addr[ADDR_W-1:OFS_W];
  assign alloc_line = alloc_addr[ADDR_W-1:OFS_W];

  logic [NUM_ENT-1:0] vld_vec, unc_vec, svc_vec, hit_vec;
  logic [NUM_ENT-1:0] wr_vec, clr_vec, mark_vec;
  logic               any_free, alloc_fire;

  assign alloc_fire = alloc_valid && any_free;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [LINE_W-1:0] line_q;
    ent_flags_t        flags_q;

    assign wr_vec[i]   = alloc_fire && (alloc_idx == IDX_W'(i));
    assign clr_vec[i]  = dealloc_valid && (dealloc_idx == IDX_W'(i));
    assign mark_vec[i] = svc_valid && (svc_idx == IDX_W'(i));

    msm_entry #(.LINE_W(LINE_W)) u_entry (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_vec[i]),
      .wr_line (alloc_line),
      .wr_sec  (alloc_secure),
      .wr_unc  (alloc_uncache),
      .clr_en  (clr_vec[i]),
      .svc_en  (mark_vec[i]),
      .line_q  (line_q),
      .flags_q (flags_q)
    );

    msm_cmp #(.LINE_W(LINE_W)) u_cmp (
      .ent_line  (line_q),
      .ent_flags (flags_q),
      .key_line  (lk_line),
      .key_sec   (lk_secure),
      .match     (hit_vec[i])
    );

    assign vld_vec[i] = flags_q.vld;
    assign unc_vec[i] = flags_q.unc;
    assign svc_vec[i] = flags_q.svc;
  end

  msm_lowest #(.N(NUM_ENT), .IDX_W(IDX_W)) u_free_pick (
    .req (~vld_vec),
    .any (any_free),
    .idx (alloc_idx)
  );

  msm_lowest #(.N(NUM_ENT), .IDX_W(IDX_W)) u_hit_pick (
    .req (hit_vec),
    .any (lk_hit),
    .idx (lk_idx)
  );

  assign lk_in_svc   = lk_hit && svc_vec[lk_idx];
  assign alloc_ready = any_free;
  assign full        = !any_free;

  // R5: callers never open two cacheable entries for one line and secure value
  assert_single_match_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R4: a reported hit is always a valid, cacheable entry
  assert_hit_cacheable_R4: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (vld_vec[lk_idx] && !unc_vec[lk_idx]));

  // R6: the offered slot is free
  assert_offer_free_R6: assert property (@(posedge clk) disable iff (rst)
    alloc_ready |-> !vld_vec[alloc_idx]);

  // R7: a request against a full file changes nothing
  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && full && !dealloc_valid) |=> $stable(vld_vec));

endmodule

// File: tb/msm_matcher_bench.sv
`timescale 1ns/1ps
module msm_matcher_bench;

  localparam int N  = 4;
  localparam int AW = 32;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] lk_addr;
  logic          lk_secure;
  logic          lk_hit, lk_in_svc;
  logic [IW-1:0] lk_idx;
  logic          alloc_valid, alloc_ready, alloc_secure, alloc_uncache;
  logic [AW-1:0] alloc_addr;
  logic [IW-1:0] alloc_idx;
  logic          dealloc_valid, svc_valid;
  logic [IW-1:0] dealloc_idx, svc_idx;
  logic          full;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  msm_matcher #(.NUM_ENT(N), .ADDR_W(AW), .LINE_BYTES(64)) u_msm_matcher (
    .clk(clk), .rst(rst),
    .lk_addr(lk_addr), .lk_secure(lk_secure),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_in_svc(lk_in_svc),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_addr(alloc_addr), .alloc_secure(alloc_secure),
    .alloc_uncache(alloc_uncache), .alloc_idx(alloc_idx),
    .dealloc_valid(dealloc_valid), .dealloc_idx(dealloc_idx),
    .svc_valid(svc_valid), .svc_idx(svc_idx),
    .full(full)
  );

  // Scoreboard: expected lookup results {hit, idx, in_svc}
  logic [3:0] q_exp[$];
  string      q_tag[$];
  event       look_ev;

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per driven lookup
  initial begin
    forever begin
      @(look_ev);
      #1;
      if (q_exp.size() > 0) begin
        logic [3:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check({t, " hit"}, int'(lk_hit), int'(e[3]));
        if (e[3]) begin
          check({t, " idx"}, int'(lk_idx), int'(e[2:1]));
          check({t, " in_svc"}, int'(lk_in_svc), int'(e[0]));
        end else begin
          check({t, " in_svc"}, int'(lk_in_svc), 0);
        end
      end
    end
  end

  // Driver: one lookup per low clock phase
  task automatic lookup(logic [AW-1:0] a, logic s, logic hit, int idx, logic sv, string tag);
    @(negedge clk);
    lk_addr   = a;
    lk_secure = s;
    q_exp.push_back({hit, IW'(idx), sv});
    q_tag.push_back(tag);
    -> look_ev;
    #2;
  endtask

  task automatic alloc(logic [AW-1:0] a, logic s, logic u, int exp_idx, string tag);
    @(negedge clk);
    alloc_addr = a; alloc_secure = s; alloc_uncache = u; alloc_valid = 1'b1;
    #1;
    check({tag, " alloc_ready"}, int'(alloc_ready), 1);
    check({tag, " alloc_idx"}, int'(alloc_idx), exp_idx);
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic release_ent(int idx);
    @(negedge clk);
    dealloc_idx = IW'(idx); dealloc_valid = 1'b1;
    @(posedge clk); #1;
    dealloc_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lk_addr = '0; lk_secure = 1'b0;
    alloc_valid = 1'b0; alloc_addr = '0; alloc_secure = 1'b0; alloc_uncache = 1'b0;
    dealloc_valid = 1'b0; dealloc_idx = '0; svc_valid = 1'b0; svc_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1 full", int'(full), 0);
    check("R1 alloc_ready", int'(alloc_ready), 1);
    check("R1 alloc_idx", int'(alloc_idx), 0);
    lookup(32'h1000, 1'b0, 1'b0, 0, 1'b0, "R1 empty lookup");

    // R2 / R5: line match regardless of offset, same-cycle response
    alloc(32'h1008, 1'b0, 1'b0, 0, "R6 first");
    lookup(32'h1030, 1'b0, 1'b1, 0, 1'b0, "R2 same line");
    lookup(32'h103F, 1'b0, 1'b1, 0, 1'b0, "R5 last byte");
    lookup(32'h1040, 1'b0, 1'b0, 0, 1'b0, "R2 next line");
    lookup(32'h1000, 1'b1, 1'b0, 0, 1'b0, "R3 secure differs");

    // R3 secure entry
    alloc(32'h2000, 1'b1, 1'b0, 1, "R6 second");
    lookup(32'h2010, 1'b1, 1'b1, 1, 1'b0, "R3 secure hit");
    lookup(32'h2010, 1'b0, 1'b0, 0, 1'b0, "R3 nonsecure miss");

    // R4 uncacheable entry never matches
    alloc(32'h3000, 1'b0, 1'b1, 2, "R6 third");
    lookup(32'h3000, 1'b0, 1'b0, 0, 1'b0, "R4 uncacheable");
    lookup(32'h3020, 1'b1, 1'b0, 0, 1'b0, "R4 uncacheable secure");
    @(negedge clk);
    check("R7 not full", int'(full), 0);

    // R7 full and ignored allocation
    alloc(32'h4000, 1'b0, 1'b0, 3, "R6 fourth");
    @(negedge clk);
    check("R7 full", int'(full), 1);
    check("R7 ready low", int'(alloc_ready), 0);
    alloc_addr = 32'h5000; alloc_secure = 1'b0; alloc_uncache = 1'b0; alloc_valid = 1'b1;
    @(posedge clk); #1;
    alloc_valid = 1'b0;
    lookup(32'h5000, 1'b0, 1'b0, 0, 1'b0, "R7 ignored alloc");
    lookup(32'h4000, 1'b0, 1'b1, 3, 1'b0, "R7 existing kept");
    @(negedge clk);
    check("R7 still full", int'(full), 1);

    // R9 in-service marking
    @(negedge clk);
    svc_idx = 2'd1; svc_valid = 1'b1;
    @(posedge clk); #1;
    svc_valid = 1'b0;
    lookup(32'h2000, 1'b1, 1'b1, 1, 1'b1, "R9 marked");
    lookup(32'h1000, 1'b0, 1'b1, 0, 1'b0, "R9 unmarked");

    // R8 release and reuse
    release_ent(1);
    @(negedge clk);
    check("R8 full cleared", int'(full), 0);
    check("R8 slot offered", int'(alloc_idx), 1);
    lookup(32'h2000, 1'b1, 1'b0, 0, 1'b0, "R8 released miss");
    alloc(32'h6000, 1'b0, 1'b0, 1, "R8 reuse");
    lookup(32'h6004, 1'b0, 1'b1, 1, 1'b0, "R9 svc cleared on realloc");

    // R6 lowest free after releasing 2 then 0
    release_ent(2);
    @(negedge clk);
    check("R6 offer 2", int'(alloc_idx), 2);
    release_ent(0);
    @(negedge clk);
    check("R6 offer lowest 0", int'(alloc_idx), 0);
    lookup(32'h1000, 1'b0, 1'b0, 0, 1'b0, "R8 released first");

    // R1 reset again clears all
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    lookup(32'h4000, 1'b0, 1'b0, 0, 1'b0, "R1 reset clears");
    @(negedge clk);
    check("R1 full after reset", int'(full), 0);

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule